// File: doc/BRIEF.md
# Four-Event Edge Timestamp Capture Unit

This block timestamps edges on a single input signal. A free-running counter is latched into one of four capture registers each time the input shows the edge expected by the current step of a four-step sequence. Each step has its own edge polarity and its own option to restart the counter once the value is captured. With every restart enabled, each stored value is the spacing between two consecutive edges. With rising and falling polarities alternating, capture register 3 holds the low time and capture register 4 holds the high time, so their sum is the period.

A small register port sets up the control word, reads the four capture registers, and handles interrupts. Two sources exist: a capture on the fourth step, and counter wrap-around. The last step of the sequence can be selected. When that step is reached, one-shot mode freezes the sequence until software rearms it, and continuous mode returns it to step 1.

The sequencer is a state machine with five states. `SEQ_EV1`, `SEQ_EV2`, `SEQ_EV3` and `SEQ_EV4` each wait for one step's edge, and `SEQ_HALT` is the frozen state of one-shot mode. Its transitions are:
- *advance*: a capture on step k moves to step k+1.
- *wrap*: a capture on the stop step in continuous mode moves to `SEQ_EV1`.
- *halt*: a capture on the stop step in one-shot mode moves to `SEQ_HALT`.
- *rearm*: a rearm write moves any state to `SEQ_EV1`.

Top module: `edge_stamp_capture`

## Requirements
- R1: The input passes through two synchroniser flops and an edge detector, so a capture takes place on the third rising clock edge after the input changes. Two input changes D cycles apart therefore differ by D in their capture timing.
- R2: Control bits 0, 2, 4 and 6 choose the edge for steps 1 to 4: 0 selects a rising edge and 1 selects a falling edge. An edge of the other direction leaves the step waiting.
- R3: Control bits 1, 3, 5 and 7 reload the counter to 1 when steps 1 to 4 capture, so the next capture reads the number of cycles since that step. When a step's bit is 0, the count keeps accumulating through that step.
- R4: When control bit 8 (load enable) is 0, edges neither change the capture registers nor advance the sequence.
- R5: Control bit 20 lets the counter increment each cycle. When it is 0, the counter holds its value; a reload still sets it to 1.
- R6: When control bit 16 is 1 (one-shot), a capture on the stop step enters `SEQ_HALT`. In that state, later edges change no capture register until a rearm.
- R7: Control bits 18:17 hold the stop step minus one (3 selects step 4). In continuous mode (bit 16 = 0), the capture on the stop step returns the sequence to step 1, and the steps after it are never loaded.
- R8: Writing 1 to control bit 19 returns the sequence to step 1 from any state. This bit is not stored and reads back as 0.
- R9: The capture registers for steps 1 to 4 read at offsets 0x08, 0x0C, 0x10 and 0x14. The control word is written and read at 0x28, and every other control bit reads 0.
- R10: The register at 0x2C holds the step-4 interrupt enable (bit 4, writable) and the step-4 flag (bit 20, read-only). The flag sets on every capture in step 4, whether or not the enable is set.
- R11: In the register at 0x2C, bit 5 is the wrap interrupt enable and bit 21 is the wrap flag. The flag sets when the running counter passes from all ones to zero.
- R12: The irq output is a latch. It sets when a flag sets while that flag's enable is 1, and it holds until a write of 1 to bit 0 at 0x30.
- R13: At 0x30, writing 1 to bit 4 clears the step-4 flag and writing 1 to bit 5 clears the wrap flag. If a clear and a new setting of the same flag fall in one cycle, the flag and the latch stay set.
- R14: After reset, every register and irq read as 0, and the sequence waits in `SEQ_EV1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous signal whose edges are timed |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for both reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Global interrupt latch |

## Verification
A capture, and the flag it sets, are both due on the third rising edge after the input changes. The bench therefore changes the input only on falling edges and reads back at least four cycles after the last change in a pattern. A register write takes effect on the rising edge after the strobe, and reads are combinational, so each read is sampled one time step after a falling edge.

The same-cycle clear test is timed so that the write strobe covers exactly the capture edge of step 4. Spacings are swept over every combination of high time and low time from 1 to 5 cycles, and the expected deltas are the spacings themselves or running sums of them.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    localparam int REG_W = 32;

    // register offsets
    localparam int OFF_CAP1 = 'h08;
    localparam int OFF_CAP2 = 'h0C;
    localparam int OFF_CAP3 = 'h10;
    localparam int OFF_CAP4 = 'h14;
    localparam int OFF_CTRL = 'h28;
    localparam int OFF_IRQE = 'h2C;
    localparam int OFF_ICLR = 'h30;

    // control word fields
    localparam int CTL_LDEN    = 8;
    localparam int CTL_ONESHOT = 16;
    localparam int CTL_STOP_LO = 17;
    localparam int CTL_REARM   = 19;
    localparam int CTL_RUN     = 20;
    localparam logic [REG_W-1:0] CTL_KEEP = 32'h0017_01FF;

    // interrupt fields
    localparam int IEN_EV4  = 4;
    localparam int IEN_OVF  = 5;
    localparam int IFLG_EV4 = 20;
    localparam int IFLG_OVF = 21;
    localparam int ICLR_IRQ = 0;

    typedef enum logic [2:0] {
        SEQ_EV1,
        SEQ_EV2,
        SEQ_EV3,
        SEQ_EV4,
        SEQ_HALT
    } seq_state_t;

endpackage

// File: rtl/edge_stamp_sync.sv
module edge_stamp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= ONE;
        end else if (run) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt       = cnt_q;
    assign ovf_pulse = run & ~reload & (&cnt_q);

endmodule

// File: rtl/edge_stamp_seq.sv
module edge_stamp_seq
    import edge_stamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       fall,
    input  logic [3:0] pol,
    input  logic       ld_en,
    input  logic       oneshot,
    input  logic [1:0] stop_sel,
    input  logic       rearm,
    output logic       fire,
    output logic [1:0] idx,
    output logic       frozen
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       live;
    logic       hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_EV1;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        idx  = 2'd0;
        live = 1'b1;
        unique case (state_q)
            SEQ_EV1:  idx = 2'd0;
            SEQ_EV2:  idx = 2'd1;
            SEQ_EV3:  idx = 2'd2;
            SEQ_EV4:  idx = 2'd3;
            SEQ_HALT: live = 1'b0;
            default:  live = 1'b0;
        endcase
        hit    = pol[idx] ? fall : rise;
        fire   = live & ld_en & ~rearm & hit;
        frozen = (state_q == SEQ_HALT);
    end

    // transitions: advance, wrap, halt, rearm
    always_comb begin
        state_d = state_q;
        if (rearm) begin
            state_d = SEQ_EV1;
        end else if (fire) begin
            if (idx == stop_sel) begin
                state_d = oneshot ? SEQ_HALT : SEQ_EV1;
            end else begin
                unique case (state_q)
                    SEQ_EV1: state_d = SEQ_EV2;
                    SEQ_EV2: state_d = SEQ_EV3;
                    SEQ_EV3: state_d = SEQ_EV4;
                    default: state_d = SEQ_EV1;
                endcase
            end
        end
    end

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
    import edge_stamp_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              irq
);

    localparam int NUM_EV = 4;

    logic [REG_W-1:0] ctrl_q;
    logic             en_ev4_q;
    logic             en_ovf_q;
    logic             flg_ev4_q;
    logic             flg_ovf_q;
    logic             irq_q;

    logic             wr_ctrl;
    logic             wr_irqe;
    logic             wr_iclr;
    logic             rearm;
    logic             latch_clr;
    logic             rise;
    logic             fall;
    logic             fire;
    logic [1:0]       idx;
    logic             seq_frozen;
    logic             cnt_reload;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_pulse;
    logic             set_ev4;
    logic [3:0]       pol_bits;
    logic [3:0]       rst_bits;
    logic [CNT_W-1:0] cap_q [NUM_EV];

    assign wr_ctrl   = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign wr_irqe   = wr_en && (addr == ADDR_W'(OFF_IRQE));
    assign wr_iclr   = wr_en && (addr == ADDR_W'(OFF_ICLR));
    assign rearm     = wr_ctrl && wr_data[CTL_REARM];
    assign latch_clr = wr_iclr && wr_data[ICLR_IRQ];

    for (genvar g = 0; g < NUM_EV; g++) begin : g_bits
        assign pol_bits[g] = ctrl_q[2*g];
        assign rst_bits[g] = ctrl_q[2*g+1];
    end

    edge_stamp_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sig_in),
        .rise (rise),
        .fall (fall)
    );

    edge_stamp_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .fall    (fall),
        .pol     (pol_bits),
        .ld_en   (ctrl_q[CTL_LDEN]),
        .oneshot (ctrl_q[CTL_ONESHOT]),
        .stop_sel(ctrl_q[CTL_STOP_LO+1:CTL_STOP_LO]),
        .rearm   (rearm),
        .fire    (fire),
        .idx     (idx),
        .frozen  (seq_frozen)
    );

    assign cnt_reload = fire & rst_bits[idx];

    edge_stamp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q[CTL_RUN]),
        .reload   (cnt_reload),
        .cnt      (cnt_q),
        .ovf_pulse(ovf_pulse)
    );

    for (genvar g = 0; g < NUM_EV; g++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q[g] <= '0;
            end else if (fire && (idx == 2'(g))) begin
                cap_q[g] <= cnt_q;
            end
        end
    end

    assign set_ev4 = fire && (idx == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            en_ev4_q  <= 1'b0;
            en_ovf_q  <= 1'b0;
            flg_ev4_q <= 1'b0;
            flg_ovf_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wr_data & CTL_KEEP;
            end
            if (wr_irqe) begin
                en_ev4_q <= wr_data[IEN_EV4];
                en_ovf_q <= wr_data[IEN_OVF];
            end
            flg_ev4_q <= set_ev4 | (flg_ev4_q & ~(wr_iclr & wr_data[IEN_EV4]));
            flg_ovf_q <= ovf_pulse | (flg_ovf_q & ~(wr_iclr & wr_data[IEN_OVF]));
            irq_q     <= (set_ev4 & en_ev4_q) | (ovf_pulse & en_ovf_q)
                       | (irq_q & ~latch_clr);
        end
    end

    assign irq = irq_q;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_W'(OFF_CAP1): rd_data = REG_W'(cap_q[0]);
            ADDR_W'(OFF_CAP2): rd_data = REG_W'(cap_q[1]);
            ADDR_W'(OFF_CAP3): rd_data = REG_W'(cap_q[2]);
            ADDR_W'(OFF_CAP4): rd_data = REG_W'(cap_q[3]);
            ADDR_W'(OFF_CTRL): rd_data = ctrl_q;
            ADDR_W'(OFF_IRQE): begin
                rd_data[IEN_EV4]  = en_ev4_q;
                rd_data[IEN_OVF]  = en_ovf_q;
                rd_data[IFLG_EV4] = flg_ev4_q;
                rd_data[IFLG_OVF] = flg_ovf_q;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/edge_stamp_capture_chk.sv
module edge_stamp_capture_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             latch_clr,
    input logic             cnt_reload,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_pulse,
    input logic             flg_ovf_q,
    input logic             seq_frozen,
    input logic             rearm
);

    // R12
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !latch_clr |=> irq);

    // R3
    reload_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reload |=> cnt_q == CNT_W'(1));

    // R11
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> flg_ovf_q);

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_frozen && !rearm |=> seq_frozen);

    // R8
    rearm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !seq_frozen);

endmodule

bind edge_stamp_capture edge_stamp_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .latch_clr (latch_clr),
    .cnt_reload(cnt_reload),
    .cnt_q     (cnt_q),
    .ovf_pulse (ovf_pulse),
    .flg_ovf_q (flg_ovf_q),
    .seq_frozen(seq_frozen),
    .rearm     (rearm)
);

// File: tb/edge_stamp_capture_test.sv
module edge_stamp_capture_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sig_in = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic              irq;

    int checks = 0;
    int failures = 0;

    edge_stamp_capture #(.CNT_W(8), .ADDR_W(ADDR_W)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .irq    (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ctl(input logic [3:0] pol, input logic [3:0] rst,
                                        input logic ld, input logic one, input logic [1:0] stop,
                                        input logic rearm, input logic run);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) begin
            w[2*i]   = pol[i];
            w[2*i+1] = rst[i];
        end
        w[8] = ld; w[16] = one; w[18:17] = stop; w[19] = rearm; w[20] = run;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = ADDR_W'(a);
        #1;
        d = rd_data;
    endtask

    task automatic drive(input logic v, input int n);
        sig_in = v;
        repeat (n) @(negedge clk);
    endtask

    // rise, high h, fall, low l, rise, high h, fall, settle
    task automatic pulses(input int h, input int l);
        drive(1'b1, h);
        drive(1'b0, l);
        drive(1'b1, h);
        drive(1'b0, 6);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep2;
        logic [31:0] keep3;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R14 reset state
        rd('h28, v); check("R14 ctrl", v, 0);
        rd('h2C, v); check("R14 irq reg", v, 0);
        rd('h10, v); check("R14 cap3", v, 0);
        check("R14 irq", {31'b0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd('h14, v); check("R14 cap4 after release", v, 0);

        // R1 R2 R3 R9 sweep of high/low spacing, one-shot stop at step 4
        for (int h = 1; h <= 5; h++) begin
            for (int l = 1; l <= 5; l++) begin
                w = ctl(4'b1010, 4'b1111, 1, 1, 2'd3, 1, 1);
                wr('h28, w);
                pulses(h, l);
                rd('h0C, v); check("R1 cap2 high time", v, h);
                rd('h10, v); check("R9 cap3 low time", v, l);
                rd('h14, v); check("R3 cap4 high time", v, h);
                rd('h2C, v); check("R10 step4 flag", {31'b0, v[20]}, 1);
                wr('h30, 32'h31);
            end
        end
        rd('h28, v); check("R8 R9 ctrl readback", v, w & ~32'h0008_0000);

        // R6 frozen: new pulses change nothing
        rd('h0C, keep2);
        pulses(9, 9);
        rd('h0C, v); check("R6 cap2 frozen", v, keep2);
        rd('h14, v); check("R6 cap4 frozen", v, 5);

        // R8 rearm resumes
        wr('h28, ctl(4'b1010, 4'b1111, 1, 1, 2'd3, 1, 1));
        pulses(6, 2);
        rd('h0C, v); check("R8 cap2 after rearm", v, 6);
        rd('h10, v); check("R8 cap3 after rearm", v, 2);

        // R2 inverted polarities: step 1 falling
        drive(1'b1, 4);
        wr('h28, ctl(4'b0101, 4'b1111, 1, 1, 2'd3, 1, 1));
        drive(1'b0, 3);
        drive(1'b1, 5);
        drive(1'b0, 2);
        drive(1'b1, 6);
        rd('h0C, v); check("R2 cap2 low", v, 3);
        rd('h10, v); check("R2 cap3 high", v, 5);
        rd('h14, v); check("R2 cap4 low", v, 2);
        drive(1'b0, 4);

        // R3 only step 1 reloads: running sums
        wr('h28, ctl(4'b1010, 4'b0001, 1, 1, 2'd3, 1, 1));
        drive(1'b1, 4);
        drive(1'b0, 3);
        drive(1'b1, 2);
        drive(1'b0, 6);
        rd('h0C, v); check("R3 cap2 since step1", v, 4);
        rd('h10, v); check("R3 cap3 accumulated", v, 7);
        rd('h14, v); check("R3 cap4 accumulated", v, 9);

        // R5 counter stopped: reload to 1 then hold
        wr('h28, ctl(4'b1010, 4'b1111, 1, 1, 2'd3, 1, 0));
        pulses(5, 4);
        rd('h0C, v); check("R5 cap2 held", v, 1);
        rd('h10, v); check("R5 cap3 held", v, 1);

        // R7 continuous with stop at step 2: wraps, cap3 untouched
        rd('h10, keep3);
        wr('h28, ctl(4'b0010, 4'b1111, 1, 0, 2'd1, 1, 1));
        drive(1'b1, 3);
        drive(1'b0, 4);
        drive(1'b1, 7);
        drive(1'b0, 6);
        rd('h0C, v); check("R7 cap2 second lap", v, 7);
        rd('h10, v); check("R7 cap3 untouched", v, keep3);
        rd('h08, v); check("R7 cap1 second lap", v, 4);

        // R4 loads disabled
        wr('h28, ctl(4'b1010, 4'b1111, 0, 1, 2'd3, 1, 1));
        rd('h0C, keep2);
        pulses(3, 3);
        rd('h0C, v); check("R4 cap2 unchanged", v, keep2);
        rd('h10, v); check("R4 cap3 unchanged", v, keep3);

        // R10 R12 R13 step-4 interrupt with clear in capture cycle
        wr('h30, 32'h31);
        wr('h2C, 32'h10);
        check("R12 irq idle", {31'b0, irq}, 0);
        wr('h28, ctl(4'b1010, 4'b1111, 1, 1, 2'd3, 1, 1));
        drive(1'b1, 2);
        drive(1'b0, 2);
        drive(1'b1, 2);
        sig_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr('h30, 32'h31);
        rd('h2C, v); check("R13 flag survives clear", {31'b0, v[20]}, 1);
        check("R13 irq survives clear", {31'b0, irq}, 1);
        rd('h14, v); check("R10 cap4", v, 2);
        wr('h30, 32'h01);
        check("R12 irq cleared", {31'b0, irq}, 0);
        rd('h2C, v); check("R12 flag kept", {31'b0, v[20]}, 1);
        wr('h30, 32'h10);
        rd('h2C, v); check("R13 flag cleared", {31'b0, v[20]}, 0);

        // R11 wrap interrupt
        wr('h2C, 32'h20);
        wr('h28, ctl(4'b0000, 4'b0000, 0, 0, 2'd0, 0, 1));
        repeat (270) @(negedge clk);
        wr('h28, ctl(4'b0000, 4'b0000, 0, 0, 2'd0, 0, 0));
        rd('h2C, v); check("R11 wrap flag", {31'b0, v[21]}, 1);
        check("R11 irq on wrap", {31'b0, irq}, 1);
        wr('h30, 32'h21);
        rd('h2C, v); check("R11 wrap flag cleared", {31'b0, v[21]}, 0);
        check("R12 irq cleared after wrap", {31'b0, irq}, 0);

        finish_run();
    end

endmodule